// File: doc/BRIEF.md
# Range-Normalized Admission FIFO Scheduler

This block sits in front of one first-in first-out output queue and decides, packet by packet, whether an arrival may enter. Each arrival carries a rank and a payload tag. The block keeps a running lowest rank and a running highest rank. From these it forms a relative score, the rank's position inside the observed range. An arrival is kept when that score is larger than the fraction of the queue already in use. This lets low-priority traffic back off as the queue fills, without keeping a sorted structure.

The only scheduling state is three registers and the queue itself. The registers are the range floor, the range ceiling and the occupancy count. A small reserved band at the bottom of the queue accepts every arrival. A full queue rejects every arrival. Admitted packets leave strictly in arrival order through a dequeue port that the output link drives. Each rejected packet produces a one-cycle drop pulse.

Top module: `range_admit_fifo`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `out_valid` and `drop_pulse` are low. `in_ready` is low during reset and high from the first clock edge after reset onward.
- R2: The first accepted arrival after reset sets both the range floor and the range ceiling to its rank. Every accepted arrival widens the floor and ceiling to include its own rank before its score is evaluated.
- R3: Outside the cases in R4, R5 and R6, an arrival is admitted if and only if (rank − floor) × DEPTH > occupancy × (ceiling − floor). The products are computed at full width, and floor and ceiling already include the arrival.
- R4: While occupancy is below GUARANTEE, every arrival is admitted.
- R5: When the updated ceiling equals the updated floor, the arrival is admitted unless the queue is full.
- R6: When occupancy equals DEPTH, the arrival is dropped, even if a dequeue happens in the same cycle. Occupancy never exceeds DEPTH.
- R7: `drop_pulse` is high for exactly one cycle, the cycle after a rejected arrival. It is low after any cycle with no rejected arrival.
- R8: `out_valid` is high exactly when occupancy is nonzero. `out_tag` shows the oldest admitted tag. Tags leave in admission order, and a dequeue happens when `out_valid` and `out_ready` are both high.
- R9: Admission uses the occupancy from before the cycle's dequeue. An admitted arrival together with a dequeue in the same cycle leaves occupancy unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An arrival is offered |
| in_ready | output | 1 | The block accepts an arrival this cycle |
| in_rank | input | RANK_W | Rank of the arrival (lower is not assumed better; only the position in the range matters) |
| in_tag | input | TAG_W | Payload tag stored for admitted arrivals |
| out_ready | input | 1 | The output link takes the head entry |
| out_valid | output | 1 | The queue holds at least one entry |
| out_tag | output | TAG_W | Tag at the queue head |
| drop_pulse | output | 1 | One-cycle pulse per rejected arrival |

## Verification
The admit or drop decision for an arrival shows one clock edge later. `drop_pulse` is registered, and the queue head and `out_valid` reflect the write and the occupancy update made at that same edge. The bench drives each cycle's inputs at the falling edge and works out the expected result from its own floor, ceiling and queue model. At the next falling edge, exactly one edge later, it compares the drop pulse, `out_valid` and `out_tag`. The sweep fills the queue to every level from empty to full. At each level it probes ranks across the whole range with a dequeue in the same cycle. This places the decision at each side of the cross-multiplied threshold, inside the reserved band and at the full boundary.

// File: rtl/range_admit_pkg.sv
package range_admit_pkg;

  // Why an arrival was kept or refused.
  typedef enum logic [1:0] {
    ADM_RESERVED = 2'd0,
    ADM_FLAT     = 2'd1,
    ADM_SCORE    = 2'd2,
    ADM_REJECT   = 2'd3
  } admit_cause_t;

  function automatic logic cause_keeps(input admit_cause_t c);
    return c != ADM_REJECT;
  endfunction

endpackage

// File: rtl/rank_range_tracker.sv
module rank_range_tracker #(
  parameter int RANK_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              upd,
  input  logic [RANK_W-1:0] rank,
  output logic              seen,
  output logic [RANK_W-1:0] floor_q,
  output logic [RANK_W-1:0] ceil_q,
  output logic [RANK_W-1:0] floor_eff,
  output logic [RANK_W-1:0] ceil_eff
);

  // The effective range includes the arrival, so the score sees it at once.
  always_comb begin
    if (!seen) begin
      floor_eff = rank;
      ceil_eff  = rank;
    end else begin
      floor_eff = (rank < floor_q) ? rank : floor_q;
      ceil_eff  = (rank > ceil_q)  ? rank : ceil_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      seen    <= 1'b0;
      floor_q <= '0;
      ceil_q  <= '0;
    end else if (upd) begin
      seen    <= 1'b1;
      floor_q <= floor_eff;
      ceil_q  <= ceil_eff;
    end
  end

endmodule

// File: rtl/admit_decider.sv
module admit_decider
  import range_admit_pkg::*;
#(
  parameter int RANK_W    = 16,
  parameter int DEPTH     = 64,
  parameter int GUARANTEE = 8,
  localparam int CNT_W    = $clog2(DEPTH + 1),
  localparam int PROD_W   = RANK_W + CNT_W
) (
  input  logic [RANK_W-1:0] rank,
  input  logic [RANK_W-1:0] floor_eff,
  input  logic [RANK_W-1:0] ceil_eff,
  input  logic [CNT_W-1:0]  occ,
  output admit_cause_t      cause
);

  logic [RANK_W-1:0] offset;
  logic [RANK_W-1:0] span;
  logic [PROD_W-1:0] score_side;
  logic [PROD_W-1:0] fill_side;
  logic              full;

  assign offset = rank - floor_eff;
  assign span   = ceil_eff - floor_eff;
  assign full   = (occ == CNT_W'(DEPTH));

  // offset/span > occ/DEPTH, rewritten without a division.
  assign score_side = PROD_W'(offset) * PROD_W'(DEPTH);
  assign fill_side  = PROD_W'(occ) * PROD_W'(span);

  always_comb begin
    if (full)
      cause = ADM_REJECT;
    else if (occ < CNT_W'(GUARANTEE))
      cause = ADM_RESERVED;
    else if (span == '0)
      cause = ADM_FLAT;
    else if (score_side > fill_side)
      cause = ADM_SCORE;
    else
      cause = ADM_REJECT;
  end

endmodule

// File: rtl/tag_fifo.sv
module tag_fifo #(
  parameter int TAG_W = 8,
  parameter int DEPTH = 64,
  localparam int AW    = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic             rd_en,
  output logic [TAG_W-1:0] rd_tag,
  output logic [CNT_W-1:0] count
);

  logic [TAG_W-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr;
  logic [AW-1:0]    rd_ptr;

  // Storage without reset so the tools can map it to RAM.
  always_ff @(posedge clk) begin
    if (wr_en)
      mem[wr_ptr] <= wr_tag;
  end

  assign rd_tag = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (wr_en)
        wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (rd_en)
        rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      case ({wr_en, rd_en})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

endmodule

// File: rtl/range_admit_fifo.sv
module range_admit_fifo
  import range_admit_pkg::*;
#(
  parameter int RANK_W    = 16,
  parameter int TAG_W     = 8,
  parameter int DEPTH     = 64,
  parameter int GUARANTEE = 8,
  localparam int CNT_W    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [RANK_W-1:0] in_rank,
  input  logic [TAG_W-1:0]  in_tag,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [TAG_W-1:0]  out_tag,
  output logic              drop_pulse
);

  logic              arrive;
  logic              enq;
  logic              deq;
  logic              rng_seen;
  logic [RANK_W-1:0] rng_min;
  logic [RANK_W-1:0] rng_max;
  logic [RANK_W-1:0] eff_min;
  logic [RANK_W-1:0] eff_max;
  logic [CNT_W-1:0]  occ;
  admit_cause_t      cause;

  always_ff @(posedge clk) begin
    if (rst) in_ready <= 1'b0;
    else     in_ready <= 1'b1;
  end

  assign arrive    = in_valid && in_ready;
  assign enq       = arrive && cause_keeps(cause);
  assign out_valid = (occ != '0);
  assign deq       = out_valid && out_ready;

  rank_range_tracker #(.RANK_W(RANK_W)) u_range (
    .clk       (clk),
    .rst       (rst),
    .upd       (arrive),
    .rank      (in_rank),
    .seen      (rng_seen),
    .floor_q   (rng_min),
    .ceil_q    (rng_max),
    .floor_eff (eff_min),
    .ceil_eff  (eff_max)
  );

  admit_decider #(
    .RANK_W    (RANK_W),
    .DEPTH     (DEPTH),
    .GUARANTEE (GUARANTEE)
  ) u_decide (
    .rank      (in_rank),
    .floor_eff (eff_min),
    .ceil_eff  (eff_max),
    .occ       (occ),
    .cause     (cause)
  );

  tag_fifo #(.TAG_W(TAG_W), .DEPTH(DEPTH)) u_queue (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (enq),
    .wr_tag (in_tag),
    .rd_en  (deq),
    .rd_tag (out_tag),
    .count  (occ)
  );

  always_ff @(posedge clk) begin
    if (rst) drop_pulse <= 1'b0;
    else     drop_pulse <= arrive && !cause_keeps(cause);
  end

endmodule

// File: rtl/range_admit_chk.sv
module range_admit_chk #(
  parameter int RANK_W    = 16,
  parameter int DEPTH     = 64,
  parameter int GUARANTEE = 8,
  localparam int CNT_W    = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic              drop_pulse,
  input logic [CNT_W-1:0]  occ,
  input logic              enq,
  input logic              deq,
  input logic              rng_seen,
  input logic [RANK_W-1:0] rng_min,
  input logic [RANK_W-1:0] rng_max
);

  a_r2_floor_below_ceiling: assert property (@(posedge clk) disable iff (rst)
    rng_seen |-> (rng_min <= rng_max));

  a_r4_reserved_admits: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && occ < CNT_W'(GUARANTEE)) |=> !drop_pulse);

  a_r6_full_drops: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && occ == CNT_W'(DEPTH)) |=> drop_pulse);

  a_r6_no_overflow: assert property (@(posedge clk) disable iff (rst)
    occ <= CNT_W'(DEPTH));

  a_r7_drop_has_arrival: assert property (@(posedge clk) disable iff (rst)
    drop_pulse |-> $past(in_valid && in_ready));

  a_r9_balanced_occupancy: assert property (@(posedge clk) disable iff (rst)
    (enq && deq) |=> $stable(occ));

endmodule

bind range_admit_fifo range_admit_chk #(
  .RANK_W    (RANK_W),
  .DEPTH     (DEPTH),
  .GUARANTEE (GUARANTEE)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .drop_pulse (drop_pulse),
  .occ        (occ),
  .enq        (enq),
  .deq        (deq),
  .rng_seen   (rng_seen),
  .rng_min    (rng_min),
  .rng_max    (rng_max)
);

// File: tb/test_range_admit_fifo.sv
`timescale 1ns/1ps
module test_range_admit_fifo;

  localparam int RW = 8;
  localparam int TW = 8;
  localparam int D  = 8;
  localparam int G  = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [RW-1:0] in_rank = '0;
  logic [TW-1:0] in_tag = '0;
  logic          out_ready = 1'b0;
  logic          out_valid;
  logic [TW-1:0] out_tag;
  logic          drop_pulse;

  always #5 clk = ~clk;

  range_admit_fifo #(.RANK_W(RW), .TAG_W(TW), .DEPTH(D), .GUARANTEE(G)) i_range_admit_fifo (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_rank(in_rank), .in_tag(in_tag), .out_ready(out_ready),
    .out_valid(out_valid), .out_tag(out_tag), .drop_pulse(drop_pulse)
  );

  int    tests = 0;
  int    fails = 0;
  int    q[$];
  bit    seen = 0;
  int    mmin = 0;
  int    mmax = 0;
  bit    exp_drop = 0;
  string exp_req = "R7";
  int    tagc = 0;
  int    lfsr = 32'h1357;

  task automatic check(input string req, input int act, input int expv, input string what);
    tests++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  // At a falling edge: compare last cycle's outcome, then drive and model this cycle.
  task automatic step(input bit v, input int r, input bit ordy, input string force_req);
    bit    admit;
    bit    deq;
    int    nmin;
    int    nmax;
    int    occ;
    string req;
    @(negedge clk);
    check(exp_req, drop_pulse, exp_drop, "drop_pulse");
    check("R8", out_valid, (q.size() != 0), "out_valid");
    if (q.size() != 0) check("R8", out_tag, q[0], "out_tag order");
    occ = q.size();
    deq = ordy && (occ != 0);
    admit = 0;
    req = "R7";
    if (v) begin
      nmin = !seen ? r : (r < mmin ? r : mmin);
      nmax = !seen ? r : (r > mmax ? r : mmax);
      if (!seen) req = "R2";
      if (occ == D) begin admit = 0; req = "R6"; end
      else if (occ < G) begin admit = 1; if (seen) req = "R4"; end
      else if (nmax == nmin) begin admit = 1; req = "R5"; end
      else begin
        admit = ((r - nmin) * D) > (occ * (nmax - nmin));
        req = "R3";
      end
      seen = 1; mmin = nmin; mmax = nmax;
    end
    if (force_req != "") req = force_req;
    in_valid  = v;
    in_rank   = RW'(r);
    in_tag    = TW'(tagc);
    out_ready = ordy;
    if (deq) void'(q.pop_front());
    if (admit) q.push_back(tagc);
    tagc = (tagc + 1) % 256;
    exp_drop = v && !admit;
    exp_req  = req;
  endtask

  task automatic rnd(output int val);
    lfsr = lfsr * 1103515245 + 12345;
    val  = (lfsr >>> 16) & 32'h7fff;
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int a;
    int b;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", in_ready, 0, "in_ready in reset");
    check("R1", out_valid, 0, "out_valid in reset");
    check("R1", drop_pulse, 0, "drop in reset");
    rst = 1'b0;
    @(negedge clk);
    check("R1", in_ready, 1, "in_ready after reset");
    check("R1", out_valid, 0, "out_valid after reset");
    check("R1", drop_pulse, 0, "drop after reset");

    // Flat range: fill to full, then overflow (R5, R6).
    for (int i = 0; i < 10; i++) step(1, 50, 0, "");
    // Full with a same-cycle dequeue still drops (R9, R6).
    step(1, 50, 1, "R9");
    // Drain and check order (R8).
    for (int i = 0; i < 9; i++) step(0, 0, 1, "");
    // Widen the range (R2).
    step(1, 0, 0, "R2");
    step(1, 255, 0, "R2");

    // Sweep every fill level against probe ranks, with a same-cycle dequeue.
    for (int fill = 0; fill <= D; fill++) begin
      for (int pr = 0; pr < 256; pr += 17) begin
        while (q.size() != 0) step(0, 0, 1, "");
        for (int k = 0; k < fill; k++) step(1, 255, 0, "");
        step(1, pr, 1, "");
        step(1, pr, 0, "");
      end
    end

    // Mixed traffic.
    for (int i = 0; i < 3000; i++) begin
      rnd(a); rnd(b);
      step((a % 4) != 0, b % 256, (a % 3) == 0, "");
    end
    step(0, 0, 0, "");
    @(negedge clk);
    check(exp_req, drop_pulse, exp_drop, "drop_pulse final");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule